// File: doc/BRIEF.md
# I2C Bus Deblock Sequencer

Before a transfer, this block decides whether the I2C lines are in a usable state and, if they are not, runs the matching recovery step. A one-cycle trigger samples the synchronised SDA and SCL levels. There are four outcomes:

- **Idle lines:** nothing to do.
- **Unterminated transfer:** ask the byte master for a STOP condition.
- **SDA held low by a target:** clock SCL with open-drain pulses until SDA is let go, then ask for a STOP.
- **Both lines low:** ask for a full reinitialisation of the controller.

Each request waits for its own completion handshake. That wait is bounded by a cycle counter, so a missing handshake ends as a timeout and does not hang.

When the sequence ends, the block raises a single-cycle `done_o`. At that point `status_o` holds the outcome and `action_o` holds the chosen step. The surrounding controller raises `start_i` before it begins any transfer. It serves the STOP and reinit requests through its normal datapath. The SCL low-drive output goes to the pad's output enable.

Top module: `i2c_deblock_seq`

## Requirements
- R1: With both synchronised lines high at the trigger, `done_o` pulses in the next cycle with action NONE (0) and status OK (0), and no request output is raised.
- R2: With SDA high and SCL low at the trigger, `stop_req_o` rises the next cycle and stays high until `stop_done_i` is sampled. `done_o` follows one cycle later with action STOP (1) and status OK (0).
- R3: With SDA low and SCL high at the trigger, the block produces SCL pulses on `scl_low_o`. Each pulse drives the line low for HALF_PERIOD cycles, then releases it for HALF_PERIOD cycles.
- R4: If the synchronised SDA is high at the end of a released phase, pulsing stops after that pulse and `recover_done_o` pulses for one cycle. A STOP request then follows. On `stop_done_i`, `done_o` reports action RECOVER (2) and status OK (0).
- R5: If SDA is still low after MAX_PULSES pulses, `done_o` reports action RECOVER (2) and status STILL_STUCK (2). No STOP is requested and `recover_done_o` stays low.
- R6: With both lines low at the trigger, `reinit_req_o` stays high until `reinit_done_i` is sampled. `done_o` follows one cycle later with action REINIT (3) and status OK (0).
- R7: If a STOP or reinit wait lasts TIMEOUT_CYCLES cycles without its handshake, the request drops and `done_o` reports status TIMEOUT (1). This happens exactly TIMEOUT_CYCLES cycles after the trigger edge.
- R8: At most one of `stop_req_o`, `scl_low_o` and `reinit_req_o` is high in any cycle, and `done_o` lasts one cycle unless a new trigger arrives.
- R9: A trigger while `busy_o` is high has no effect on the running sequence, its action, or its completion time.
- R10: SDA and SCL pass through SYNC_STAGES flip-flops (reset value high) before the decision. A line change in the same cycle as the trigger does not affect the choice.
- R11: After reset, all request outputs, `done_o` and `busy_o` are low, and `status_o` and `action_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Trigger: evaluate lines and begin recovery |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| stop_done_i | input | 1 | Byte master reports the STOP condition was issued |
| reinit_done_i | input | 1 | Controller reports reinitialisation complete |
| stop_req_o | output | 1 | Request a STOP condition |
| scl_low_o | output | 1 | Drive SCL low (recovery pulse) |
| reinit_req_o | output | 1 | Request controller reinitialisation |
| recover_done_o | output | 1 | One-cycle pulse: SDA released by clock pulses |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Outcome: 0 OK, 1 TIMEOUT, 2 STILL_STUCK |
| action_o | output | 2 | Chosen step: 0 NONE, 1 STOP, 2 RECOVER, 3 REINIT |

## Verification
The bench releases SDA during a chosen recovery pulse. It checks that the pulse count matches exactly: a design that sampled SDA at the wrong phase would give one pulse too many or too few. A held-off handshake must time out on the exact cycle given by the limit, which exposes an off-by-one in the wait counter. A trigger raised mid-sequence must not restart or relabel the sequence. A line change in the trigger cycle must not reach the decision, which would happen if the synchroniser were bypassed. The stuck case must end with STILL_STUCK and no STOP request; a design that treated it as released would request a STOP there.

// File: rtl/deblk_pkg.sv
package deblk_pkg;
   typedef enum logic [1:0] {
      ACT_NONE    = 2'd0,
      ACT_STOP    = 2'd1,
      ACT_RECOVER = 2'd2,
      ACT_REINIT  = 2'd3
   } deblk_act_e;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_STUCK   = 2'd2
   } deblk_res_e;
endpackage

// File: rtl/deblk_sync.sv
module deblk_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("deblk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/deblk_wait_timer.sv
module deblk_wait_timer #(
   parameter int LIMIT = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic expired_o
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("deblk_wait_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!en_i)  cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign expired_o = en_i && (cnt == LAST);

   // R7: counter never passes the last count of the window
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/deblk_scl_pulser.sv
module deblk_scl_pulser #(
   parameter int HALF_PERIOD = 4,
   parameter int MAX_PULSES  = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic sda_high_i,
   output logic scl_low_o,
   output logic released_o,
   output logic stuck_o
);
   localparam int HW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
   localparam int PW = $clog2(MAX_PULSES + 1);
   localparam logic [HW-1:0] PH_LAST = HW'(HALF_PERIOD - 1);
   localparam logic [PW-1:0] P_MAX   = PW'(MAX_PULSES);

   generate
      if (HALF_PERIOD < 2) begin : g_bad_half
         $error("deblk_scl_pulser: HALF_PERIOD must be at least 2");
      end
      if (MAX_PULSES < 1) begin : g_bad_max
         $error("deblk_scl_pulser: MAX_PULSES must be at least 1");
      end
   endgenerate

   logic          active, low_ph;
   logic [HW-1:0] ph_cnt;
   logic [PW-1:0] pulses;
   logic [PW-1:0] pulses_nx;

   assign pulses_nx = pulses + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         low_ph     <= 1'b0;
         ph_cnt     <= '0;
         pulses     <= '0;
         released_o <= 1'b0;
         stuck_o    <= 1'b0;
      end else begin
         released_o <= 1'b0;
         stuck_o    <= 1'b0;
         if (go_i && !active) begin
            active <= 1'b1;
            low_ph <= 1'b1;
            ph_cnt <= '0;
            pulses <= '0;
         end else if (active) begin
            if (ph_cnt != PH_LAST) begin
               ph_cnt <= ph_cnt + 1'b1;
            end else begin
               ph_cnt <= '0;
               if (low_ph) begin
                  low_ph <= 1'b0;
               end else begin
                  pulses <= pulses_nx;
                  if (sda_high_i) begin
                     active     <= 1'b0;
                     released_o <= 1'b1;
                  end else if (pulses_nx == P_MAX) begin
                     active  <= 1'b0;
                     stuck_o <= 1'b1;
                  end else begin
                     low_ph <= 1'b1;
                  end
               end
            end
         end
      end
   end

   assign scl_low_o = active && low_ph;

   // R5: a stuck report only after the full pulse budget
   p_stuck_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_o |-> (pulses == P_MAX));
   // R5: pulse count never passes the budget
   p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulses <= P_MAX);
   // R4: released and stuck never reported together
   p_one_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(released_o && stuck_o));
endmodule

// File: rtl/i2c_deblock_seq.sv
module i2c_deblock_seq
   import deblk_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int TIMEOUT_CYCLES = 5000,
   parameter int HALF_PERIOD    = 4,
   parameter int MAX_PULSES     = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       sda_i,
   input  logic       scl_i,
   input  logic       stop_done_i,
   input  logic       reinit_done_i,
   output logic       stop_req_o,
   output logic       scl_low_o,
   output logic       reinit_req_o,
   output logic       recover_done_o,
   output logic       busy_o,
   output logic       done_o,
   output logic [1:0] status_o,
   output logic [1:0] action_o
);
   typedef enum logic [1:0] {S_IDLE, S_STOP, S_REC, S_REINIT} seq_st_e;

   seq_st_e    st;
   logic       sda_s, scl_s;
   logic       tmo, rec_rel, rec_stuck, rec_go;
   logic       done_q;
   deblk_res_e res_q;
   deblk_act_e act_q;

   deblk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));
   deblk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   deblk_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .en_i(st == S_STOP || st == S_REINIT),
      .expired_o(tmo));

   assign rec_go = (st == S_IDLE) && start_i && !sda_s && scl_s;

   deblk_scl_pulser #(.HALF_PERIOD(HALF_PERIOD), .MAX_PULSES(MAX_PULSES)) u_pulser (
      .clk(clk), .rst_n(rst_n), .go_i(rec_go), .sda_high_i(sda_s),
      .scl_low_o(scl_low_o), .released_o(rec_rel), .stuck_o(rec_stuck));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         done_q <= 1'b0;
         res_q  <= RES_OK;
         act_q  <= ACT_NONE;
      end else begin
         done_q <= 1'b0;
         case (st)
            S_IDLE: if (start_i) begin
               case ({sda_s, scl_s})
                  2'b11: begin
                     act_q  <= ACT_NONE;
                     res_q  <= RES_OK;
                     done_q <= 1'b1;
                  end
                  2'b10: begin act_q <= ACT_STOP;    st <= S_STOP;   end
                  2'b01: begin act_q <= ACT_RECOVER; st <= S_REC;    end
                  default: begin act_q <= ACT_REINIT; st <= S_REINIT; end
               endcase
            end
            S_STOP: if (stop_done_i) begin
               res_q <= RES_OK;      done_q <= 1'b1; st <= S_IDLE;
            end else if (tmo) begin
               res_q <= RES_TIMEOUT; done_q <= 1'b1; st <= S_IDLE;
            end
            S_REC: if (rec_rel) begin
               st <= S_STOP;
            end else if (rec_stuck) begin
               res_q <= RES_STUCK;   done_q <= 1'b1; st <= S_IDLE;
            end
            default: if (reinit_done_i) begin
               res_q <= RES_OK;      done_q <= 1'b1; st <= S_IDLE;
            end else if (tmo) begin
               res_q <= RES_TIMEOUT; done_q <= 1'b1; st <= S_IDLE;
            end
         endcase
      end
   end

   assign stop_req_o     = (st == S_STOP);
   assign reinit_req_o   = (st == S_REINIT);
   assign recover_done_o = rec_rel && (st == S_REC);
   assign busy_o         = (st != S_IDLE);
   assign done_o         = done_q;
   assign status_o       = res_q;
   assign action_o       = act_q;

   // R8: requests are mutually exclusive
   p_one_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stop_req_o, scl_low_o, reinit_req_o}));
   // R8: completion is a single-cycle pulse without a fresh trigger
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);
   // R4: a release is followed by a STOP request
   p_rec_then_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      recover_done_o |=> stop_req_o);
   // R2: STOP request held until handshake or timeout
   p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req_o && !stop_done_i && !tmo) |=> stop_req_o);
   // R6: reinit request held until handshake or timeout
   p_reinit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reinit_req_o && !reinit_done_i && !tmo) |=> reinit_req_o);
   // R9: a trigger while busy leaves the chosen action alone
   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(action_o));
endmodule

// File: tb/tb_i2c_deblock_seq.sv
module tb_i2c_deblock_seq;
   localparam int TMO  = 20;
   localparam int HALF = 3;
   localparam int MAXP = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, sda_drv = 1'b1, scl_drv = 1'b1;
   logic stop_done = 1'b0, reinit_done = 1'b0;
   logic stop_req, scl_low, reinit_req, rec_done, busy, done;
   logic [1:0] status, action;
   logic scl_line;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign scl_line = scl_drv & ~scl_low;

   i2c_deblock_seq #(.SYNC_STAGES(2), .TIMEOUT_CYCLES(TMO),
                     .HALF_PERIOD(HALF), .MAX_PULSES(MAXP)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sda_i(sda_drv), .scl_i(scl_line),
      .stop_done_i(stop_done), .reinit_done_i(reinit_done),
      .stop_req_o(stop_req), .scl_low_o(scl_low), .reinit_req_o(reinit_req),
      .recover_done_o(rec_done), .busy_o(busy), .done_o(done),
      .status_o(status), .action_o(action));

   typedef struct packed {
      logic        sda;
      logic        scl;
      logic [15:0] ack;   // cycles before handshake; FFFF = never
      logic [3:0]  rel;   // release SDA on this pulse; 0 = never
      logic [7:0]  rs;    // extra trigger at this cycle; FF = none
      logic [1:0]  act;
      logic [1:0]  st;
      logic [15:0] n;     // completion cycle; FFFF = not checked
      logic [3:0]  pul;
      logic [1:0]  rec;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b1, 1'b1, 16'd0,      4'd0, 8'hFF, 2'd0, 2'd0, 16'd0,      4'd0, 2'd0},
      '{1'b1, 1'b0, 16'd0,      4'd0, 8'hFF, 2'd1, 2'd0, 16'd1,      4'd0, 2'd0},
      '{1'b1, 1'b0, 16'd5,      4'd0, 8'd2,  2'd1, 2'd0, 16'd6,      4'd0, 2'd0},
      '{1'b1, 1'b0, 16'hFFFF,   4'd0, 8'hFF, 2'd1, 2'd1, 16'd20,     4'd0, 2'd0},
      '{1'b0, 1'b1, 16'd0,      4'd3, 8'hFF, 2'd2, 2'd0, 16'hFFFF,   4'd3, 2'd1},
      '{1'b0, 1'b1, 16'd0,      4'd0, 8'hFF, 2'd2, 2'd2, 16'hFFFF,   4'd9, 2'd0},
      '{1'b0, 1'b0, 16'd0,      4'd0, 8'hFF, 2'd3, 2'd0, 16'd1,      4'd0, 2'd0},
      '{1'b0, 1'b0, 16'hFFFF,   4'd0, 8'hFF, 2'd3, 2'd1, 16'd20,     4'd0, 2'd0}
   };

   function automatic string tag_of(int i);
      case (i)
         0: return "R1";
         1: return "R2";
         2: return "R9";
         3: return "R7";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic run_case(vec_t v, string tag);
      int n = 0, pulses = 0, lowc = 0, recs = 0, sreqs = 0, multi = 0;
      logic prev = 1'b0;
      @(negedge clk);
      sda_drv = v.sda; scl_drv = v.scl;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 400) begin
         if (int'(stop_req) + int'(scl_low) + int'(reinit_req) > 1) multi++;
         stop_done   = stop_req && (n >= int'(v.ack)) && (v.ack != 16'hFFFF);
         reinit_done = reinit_req && (n >= int'(v.ack)) && (v.ack != 16'hFFFF);
         start       = (v.rs != 8'hFF) && (n == int'(v.rs));
         if (scl_low && !prev) begin
            pulses++;
            if (v.rel != 0 && pulses == int'(v.rel)) sda_drv = 1'b1;
         end
         if (scl_low) lowc++;
         prev = scl_low;
         if (rec_done) recs++;
         if (stop_req) sreqs++;
         @(negedge clk);
         n++;
      end
      stop_done = 1'b0; reinit_done = 1'b0; start = 1'b0;
      chk(tag, "done seen", int'(done), 1);
      chk(tag, "action", int'(action), int'(v.act));
      chk(tag, "status", int'(status), int'(v.st));
      if (v.n != 16'hFFFF) chk(tag, "completion cycle", n, int'(v.n));
      chk("R3", {tag, " pulse count"}, pulses, int'(v.pul));
      chk("R3", {tag, " low cycles"}, lowc, int'(v.pul) * HALF);
      chk("R4", {tag, " recover_done pulses"}, recs, int'(v.rec));
      if (v.st == 2'd2) chk("R5", "no STOP after stuck", sreqs, 0);
      chk("R8", {tag, " exclusive requests"}, multi, 0);
      @(negedge clk);
      chk("R8", {tag, " done single cycle"}, int'(done), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "outputs after reset",
          int'({stop_req, scl_low, reinit_req, rec_done, busy, done, status, action}), 0);

      for (int i = 0; i < 8; i++) run_case(VECS[i], tag_of(i));

      // R10: a line change in the trigger cycle is not seen by the decision
      sda_drv = 1'b1; scl_drv = 1'b1;
      repeat (4) @(negedge clk);
      sda_drv = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "done with stale idle lines", int'(done), 1);
      chk("R10", "action uses synchronised level", int'(action), 0);
      chk("R10", "no request raised", int'({stop_req, scl_low, reinit_req}), 0);
      sda_drv = 1'b1;
      repeat (4) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule